// File: doc/BRIEF.md
# Biphase Receiver Sync and Enable Controller

This block is the control state machine that sits beside a biphase-mark audio line decoder. Software drives a two-bit enable code together with a wait-for-activity bit and a retry budget code over a write strobe. The decoder, which lies outside this block, reports what it sees as single-cycle strobes: line activity, a successful sync attempt, a failed sync attempt, a frame error and a frame boundary. The controller walks through idle, waiting, synchronizing, receiving and stopped states and drives sync-done, receive-active and three sticky error flags.

Synchronization and reception are separate steps. Code 01 lets the decoder lock and report sync-done without delivering samples. Code 11 also allows samples to flow once lock is held. Failed attempts are counted against a budget chosen by the retry code, and a receive window timer catches a line that goes quiet. Any error parks the block in the stopped state. Only a disable write releases that state, and a later 01 write starts a fresh synchronization.

Top module: `bmcsync_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), retry_cnt is 0, and sync_done, rx_active and all three error flags are low. The state codes are 0 idle, 1 waiting, 2 synchronizing, 3 receiving and 4 stopped.
- R2: A write whose enable code has bit 0 set, taken in idle, moves the block at that clock edge to synchronizing when cfg_wait_act is 0, or to waiting when it is 1. In waiting, an ev_activity strobe moves the block to synchronizing.
- R3: In waiting, the ev_sync_fail and ev_frame_err strobes have no effect: the state stays waiting, retry_cnt is unchanged and no error flag rises.
- R4: In synchronizing, ev_sync_ok sets sync_done. While the enable code is 01, the state stays synchronizing and rx_active stays low.
- R5: The block enters receiving only when sync_done is held (or is set in the same cycle) and the enable code is 11. A later write of code 01 in receiving returns it to synchronizing with sync_done kept. rx_active is high exactly in receiving.
- R6: The retry code selects the budget of failed attempts: 00 gives 0, 01 gives 3, 10 gives 15, 11 gives 63. Each ev_sync_fail in synchronizing adds one to retry_cnt. The fail that arrives with retry_cnt equal to the budget raises err_sync, leaves retry_cnt unchanged and enters stopped.
- R7: ev_frame_err in synchronizing or receiving raises err_frame and enters stopped. At most one error flag is ever high.
- R8: In receiving, rx_timeout_lim consecutive cycles without ev_frame_mark raise err_timeout and enter stopped. An ev_frame_mark restarts the window. A limit of 0 disables the timeout.
- R9: In stopped, enable writes with bit 0 set and all event strobes are ignored: the state, error flags and retry_cnt hold.
- R10: A write whose enable code has bit 0 clear (00, or the reserved 10) returns any state to idle at that clock edge and clears retry_cnt, sync_done and the error flags. A following 01 write restarts synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 2 | Enable code: 00 off, 01 sync only, 11 sync and receive |
| cfg_wait_act | input | 1 | Hold off sync until line activity is seen |
| cfg_retry | input | 2 | Retry budget code |
| rx_timeout_lim | input | TO_W | Receive window in cycles, 0 disables |
| ev_activity | input | 1 | Line activity strobe from the decoder |
| ev_sync_ok | input | 1 | Sync attempt succeeded |
| ev_sync_fail | input | 1 | Sync attempt failed |
| ev_frame_err | input | 1 | Frame error strobe |
| ev_frame_mark | input | 1 | Frame boundary strobe |
| state_o | output | 3 | Current state code |
| rx_active | output | 1 | Sample reception allowed |
| sync_done | output | 1 | Lock achieved in this run |
| err_sync | output | 1 | Retry budget exhausted |
| err_frame | output | 1 | Frame error seen |
| err_timeout | output | 1 | Receive window expired |
| retry_cnt | output | RETRY_W | Failed sync attempts counted |

## Verification
The bench builds the block with its defaults: a 6-bit retry counter, so the largest budget of 63 fits without wrapping, and an 8-bit timeout limit. The limit is driven as a port, so the bench sets a 3-cycle window to test expiry and a window restart by a frame mark, then sets 0 to show the timer disabled over a long stretch in receiving. The 0, 3 and 15 budgets are run up to the exact failing attempt, which covers the boundary between the last allowed retry and the error.

// File: rtl/bmcsync_pkg.sv
package bmcsync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_SYNC = 3'd2,
    ST_RECV = 3'd3,
    ST_STOP = 3'd4
  } sync_state_e;

  localparam logic [1:0] EN_SYNC_RX = 2'b11;

  // Budget of failed attempts for a retry code: 0, 3, 15, 63
  function automatic logic [7:0] retry_budget(input logic [1:0] code);
    logic [7:0] one;
    one = 8'd1;
    return (one << (3'd2 * {1'b0, code})) - 8'd1;
  endfunction

endpackage

// File: rtl/bmcsync_cfg.sv
module bmcsync_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] en_in,
  input  logic       wait_in,
  input  logic [1:0] retry_in,
  output logic [1:0] en_eff,
  output logic       wait_eff,
  output logic [1:0] retry_eff,
  output logic       clear
);

  logic [1:0] en_q;
  logic       wait_q;
  logic [1:0] retry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 2'b00;
      wait_q  <= 1'b0;
      retry_q <= 2'b00;
    end else if (wr) begin
      en_q    <= en_in;
      wait_q  <= wait_in;
      retry_q <= retry_in;
    end
  end

  // A write takes effect in the cycle it is presented
  always_comb begin
    en_eff    = wr ? en_in    : en_q;
    wait_eff  = wr ? wait_in  : wait_q;
    retry_eff = wr ? retry_in : retry_q;
    clear     = wr && !en_in[0];
  end

endmodule

// File: rtl/bmcsync_retry.sv
module bmcsync_retry #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fail,
  input  logic [CNT_W-1:0] budget,
  output logic [CNT_W-1:0] cnt,
  output logic             exhausted
);

  logic cnt_en;

  always_comb begin
    exhausted = fail && (cnt == budget);
    cnt_en    = clear || (fail && !exhausted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= clear ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bmcsync_timer.sv
module bmcsync_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            mark,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);

  logic [TO_W-1:0] cnt;
  logic            restart;

  always_comb begin
    expire  = run && !mark && (limit != '0) && (cnt == limit - 1'b1);
    restart = !run || mark || expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= restart ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bmcsync_ctrl.sv
module bmcsync_ctrl #(
  parameter int RETRY_W = 6,
  parameter int TO_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_en,
  input  logic               cfg_wait_act,
  input  logic [1:0]         cfg_retry,
  input  logic [TO_W-1:0]    rx_timeout_lim,
  input  logic               ev_activity,
  input  logic               ev_sync_ok,
  input  logic               ev_sync_fail,
  input  logic               ev_frame_err,
  input  logic               ev_frame_mark,
  output logic [2:0]         state_o,
  output logic               rx_active,
  output logic               sync_done,
  output logic               err_sync,
  output logic               err_frame,
  output logic               err_timeout,
  output logic [RETRY_W-1:0] retry_cnt
);
  import bmcsync_pkg::*;

  localparam int BUD_W = 8;

  sync_state_e        state_q, state_d;
  logic [1:0]         en_eff, retry_code;
  logic               wait_eff, clear;
  logic               fail_cnt, exhausted, expire;
  logic [RETRY_W-1:0] budget;
  logic [BUD_W-1:0]   budget_full;
  logic               set_sd, set_es, set_ef, set_et;
  logic               flag_en;

  bmcsync_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .en_in     (cfg_en),
    .wait_in   (cfg_wait_act),
    .retry_in  (cfg_retry),
    .en_eff    (en_eff),
    .wait_eff  (wait_eff),
    .retry_eff (retry_code),
    .clear     (clear)
  );

  always_comb begin
    budget_full = retry_budget(retry_code);
    budget      = budget_full[RETRY_W-1:0];
    fail_cnt    = (state_q == ST_SYNC) && ev_sync_fail && !ev_frame_err && !clear;
  end

  bmcsync_retry #(.CNT_W(RETRY_W)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .fail      (fail_cnt),
    .budget    (budget),
    .cnt       (retry_cnt),
    .exhausted (exhausted)
  );

  bmcsync_timer #(.TO_W(TO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_RECV),
    .mark   (ev_frame_mark),
    .limit  (rx_timeout_lim),
    .expire (expire)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    set_sd  = 1'b0;
    set_es  = 1'b0;
    set_ef  = 1'b0;
    set_et  = 1'b0;
    if (clear) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (en_eff[0]) state_d = wait_eff ? ST_WAIT : ST_SYNC;
        end
        ST_WAIT: begin
          if (ev_activity) state_d = ST_SYNC;
        end
        ST_SYNC: begin
          if (ev_frame_err) begin
            state_d = ST_STOP;
            set_ef  = 1'b1;
          end else if (exhausted) begin
            state_d = ST_STOP;
            set_es  = 1'b1;
          end else if (ev_sync_ok || sync_done) begin
            set_sd = ev_sync_ok;
            if (en_eff == EN_SYNC_RX) state_d = ST_RECV;
          end
        end
        ST_RECV: begin
          if (ev_frame_err) begin
            state_d = ST_STOP;
            set_ef  = 1'b1;
          end else if (expire) begin
            state_d = ST_STOP;
            set_et  = 1'b1;
          end else if (en_eff != EN_SYNC_RX) begin
            state_d = ST_SYNC;
          end
        end
        ST_STOP: state_d = ST_STOP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // State and flag registers
  always_comb flag_en = clear || set_sd || set_es || set_ef || set_et;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_done   <= 1'b0;
      err_sync    <= 1'b0;
      err_frame   <= 1'b0;
      err_timeout <= 1'b0;
    end else if (flag_en) begin
      sync_done   <= !clear && (sync_done   || set_sd);
      err_sync    <= !clear && (err_sync    || set_es);
      err_frame   <= !clear && (err_frame   || set_ef);
      err_timeout <= !clear && (err_timeout || set_et);
    end
  end

  always_comb begin
    state_o   = state_q;
    rx_active = (state_q == ST_RECV);
  end

endmodule

// File: rtl/bmcsync_ctrl_chk.sv
module bmcsync_ctrl_chk #(
  parameter int RETRY_W = 6,
  parameter int TO_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [1:0]         cfg_en,
  input logic               ev_activity,
  input logic [2:0]         state_o,
  input logic               rx_active,
  input logic               sync_done,
  input logic               err_sync,
  input logic               err_frame,
  input logic               err_timeout,
  input logic [RETRY_W-1:0] retry_cnt
);

  logic dis_wr;
  assign dis_wr = cfg_wr && !cfg_en[0];

  // R10
  clear_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (state_o == 3'd0 && retry_cnt == '0 && !sync_done &&
                !err_sync && !err_frame && !err_timeout));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !dis_wr) |=>
      (state_o == 3'd4 && $stable({err_sync, err_frame, err_timeout}) && $stable(retry_cnt)));

  // R5
  recv_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> (sync_done && state_o == 3'd3));

  // R7
  one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_sync, err_frame, err_timeout}));

  // R3
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !ev_activity && !dis_wr) |=>
      (state_o == 3'd1 && $stable(retry_cnt) && !err_sync && !err_frame));

  // R6
  retry_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sync) |-> state_o == 3'd4);

endmodule

bind bmcsync_ctrl bmcsync_ctrl_chk #(.RETRY_W(RETRY_W), .TO_W(TO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_en      (cfg_en),
  .ev_activity (ev_activity),
  .state_o     (state_o),
  .rx_active   (rx_active),
  .sync_done   (sync_done),
  .err_sync    (err_sync),
  .err_frame   (err_frame),
  .err_timeout (err_timeout),
  .retry_cnt   (retry_cnt)
);

// File: tb/bmcsync_ctrl_bench.sv
module bmcsync_ctrl_bench;

  localparam int RW = 6;
  localparam int TW = 8;
  localparam logic [2:0] IDLE = 3'd0, WAIT = 3'd1, SYNC = 3'd2, RECV = 3'd3, STOP = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr, cfg_wait_act;
  logic [1:0]    cfg_en, cfg_retry;
  logic [TW-1:0] lim;
  logic          ev_activity, ev_sync_ok, ev_sync_fail, ev_frame_err, ev_frame_mark;
  logic [2:0]    state_o;
  logic          rx_active, sync_done, err_sync, err_frame, err_timeout;
  logic [RW-1:0] retry_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bmcsync_ctrl #(.RETRY_W(RW), .TO_W(TW)) u_bmcsync_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_wait_act(cfg_wait_act), .cfg_retry(cfg_retry), .rx_timeout_lim(lim),
    .ev_activity(ev_activity), .ev_sync_ok(ev_sync_ok), .ev_sync_fail(ev_sync_fail),
    .ev_frame_err(ev_frame_err), .ev_frame_mark(ev_frame_mark),
    .state_o(state_o), .rx_active(rx_active), .sync_done(sync_done),
    .err_sync(err_sync), .err_frame(err_frame), .err_timeout(err_timeout),
    .retry_cnt(retry_cnt)
  );

  typedef struct {
    string         req;
    logic [2:0]    st;
    logic          sd, es, ef, et;
    logic [RW-1:0] rc;
  } exp_t;

  exp_t q[$];

  function automatic logic [10:0] pack_exp(exp_t e);
    return {e.st, e.st == RECV, e.sd, e.es, e.ef, e.et, 1'b0, 1'b0, 1'b0};
  endfunction

  // Monitor: compares after each clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [10:0] act, ex;
      e   = q.pop_front();
      ex  = pack_exp(e);
      act = {state_o, rx_active, sync_done, err_sync, err_frame, err_timeout, 3'b000};
      checks++;
      if (act !== ex || retry_cnt !== e.rc) begin
        fails++;
        $display("FAIL %s: st/act/sd/es/ef/et=%b retry=%0d, expected %b retry=%0d",
                 e.req, act[10:3], retry_cnt, ex[10:3], e.rc);
      end
    end
  end

  task automatic clr_strobes();
    cfg_wr = 0; ev_activity = 0; ev_sync_ok = 0; ev_sync_fail = 0;
    ev_frame_err = 0; ev_frame_mark = 0;
  endtask

  // Driver: push the expectation for the coming edge and advance one cycle
  task automatic tick(string req, logic [2:0] st, logic sd, logic es, logic ef,
                      logic et, logic [RW-1:0] rc);
    exp_t e;
    e.req = req; e.st = st; e.sd = sd; e.es = es; e.ef = ef; e.et = et; e.rc = rc;
    q.push_back(e);
    @(negedge clk);
    clr_strobes();
  endtask

  task automatic wr(logic [1:0] en, logic wa, logic [1:0] rt);
    cfg_wr = 1; cfg_en = en; cfg_wait_act = wa; cfg_retry = rt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_en = 0; cfg_wait_act = 0; cfg_retry = 0; lim = 8'd3;
    clr_strobes();
    repeat (3) @(negedge clk);
    checks++;
    if (state_o !== IDLE || rx_active || sync_done || err_sync || err_frame ||
        err_timeout || retry_cnt !== 0) begin
      fails++;
      $display("FAIL R1: state=%0d flags=%b%b%b%b%b retry=%0d, expected 0 00000 0",
               state_o, rx_active, sync_done, err_sync, err_frame, err_timeout, retry_cnt);
    end
    rst_n = 1;
    @(negedge clk);
    tick("R1", IDLE, 0, 0, 0, 0, 0);

    // Budget 3: three fails allowed, the fourth stops
    wr(2'b01, 0, 2'b01); tick("R2", SYNC, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 3; i++) begin
      ev_sync_fail = 1; tick("R6", SYNC, 0, 0, 0, 0, RW'(i));
    end
    ev_sync_fail = 1; tick("R6", STOP, 0, 1, 0, 0, 3);
    wr(2'b11, 0, 2'b01); tick("R9", STOP, 0, 1, 0, 0, 3);
    ev_sync_ok = 1; ev_sync_fail = 1; tick("R9", STOP, 0, 1, 0, 0, 3);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Wait-for-activity gate, sync-only, receive, timeout
    wr(2'b01, 1, 2'b00); tick("R2", WAIT, 0, 0, 0, 0, 0);
    ev_sync_fail = 1; ev_frame_err = 1; tick("R3", WAIT, 0, 0, 0, 0, 0);
    tick("R3", WAIT, 0, 0, 0, 0, 0);
    ev_activity = 1; tick("R2", SYNC, 0, 0, 0, 0, 0);
    ev_sync_ok = 1; tick("R4", SYNC, 1, 0, 0, 0, 0);
    tick("R4", SYNC, 1, 0, 0, 0, 0);
    wr(2'b11, 1, 2'b00); tick("R5", RECV, 1, 0, 0, 0, 0);
    tick("R8", RECV, 1, 0, 0, 0, 0);
    tick("R8", RECV, 1, 0, 0, 0, 0);
    ev_frame_mark = 1; tick("R8", RECV, 1, 0, 0, 0, 0);
    tick("R8", RECV, 1, 0, 0, 0, 0);
    tick("R8", RECV, 1, 0, 0, 0, 0);
    tick("R8", STOP, 1, 0, 0, 1, 0);
    tick("R9", STOP, 1, 0, 0, 1, 0);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Restart with no retries allowed
    wr(2'b01, 0, 2'b00); tick("R10", SYNC, 0, 0, 0, 0, 0);
    ev_sync_fail = 1; tick("R6", STOP, 0, 1, 0, 0, 0);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Direct 11: lock then receive, frame error in receive
    wr(2'b11, 0, 2'b00); tick("R5", SYNC, 0, 0, 0, 0, 0);
    ev_sync_ok = 1; tick("R5", RECV, 1, 0, 0, 0, 0);
    ev_frame_err = 1; tick("R7", STOP, 1, 0, 1, 0, 0);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Frame error during synchronizing
    wr(2'b01, 0, 2'b00); tick("R2", SYNC, 0, 0, 0, 0, 0);
    ev_frame_err = 1; ev_sync_fail = 1; tick("R7", STOP, 0, 0, 1, 0, 0);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Timeout disabled by a zero limit; drop back to sync-only
    lim = '0;
    wr(2'b11, 0, 2'b00); tick("R5", SYNC, 0, 0, 0, 0, 0);
    ev_sync_ok = 1; tick("R5", RECV, 1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) tick("R8", RECV, 1, 0, 0, 0, 0);
    wr(2'b01, 0, 2'b00); tick("R5", SYNC, 1, 0, 0, 0, 0);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Budget 15
    wr(2'b01, 0, 2'b10); tick("R6", SYNC, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 15; i++) begin
      ev_sync_fail = 1; tick("R6", SYNC, 0, 0, 0, 0, RW'(i));
    end
    ev_sync_fail = 1; tick("R6", STOP, 0, 1, 0, 0, 15);
    wr(2'b00, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);

    // Disable from waiting, reserved code 10 also disables
    wr(2'b01, 1, 2'b00); tick("R2", WAIT, 0, 0, 0, 0, 0);
    wr(2'b10, 0, 0); tick("R10", IDLE, 0, 0, 0, 0, 0);
    tick("R10", IDLE, 0, 0, 0, 0, 0);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule